// File: doc/BRIEF.md
# Multi-Subframe CRC Checker

This block checks the integrity of a received codeword that arrives one bit per clock. Each codeword is cut into a fixed number of equal subframes, and each subframe ends in its own checksum. The block runs the data part of every subframe through a shift-register CRC engine configured at compile time. It then compares the result bit by bit against the checksum that follows, and reports one pass/fail verdict per subframe. Only the data bits are forwarded on the payload output. Checksum bits are removed, so a frame of N bits yields N − C·r payload bits, where C is the subframe count and r is the CRC width.

Frames are delimited by a start marker and an end marker that qualify accepted bits. Idle cycles may appear anywhere inside a frame. The polynomial, start value, output mask, bytewise input reversal, checksum reversal, subframe count and subframe length are all parameters. With input reversal, the data length of a subframe must be a multiple of 8. The subframe length must exceed the CRC width, and the CRC width must be at least 2.

Top module: `crc_subframe_checker`

## Requirements
- R1: A frame is NUM_SUB subframes of SUB_LEN accepted bits each. The last CRC_W bits of each subframe are its checksum. Every data bit appears on `pay_bit` with `pay_valid` high one cycle after it is accepted, in arrival order. Checksum bits never appear.
- R2: The engine treats the first data bit as the highest-power coefficient. Per bit it computes fb = reg[CRC_W-1] xor bit, shifts the register left by one, and xors in POLY when fb is 1. POLY holds the coefficients below the top term, with bit i standing for power i.
- R3: The register takes the value INIT at the first bit of every subframe, not only at the first subframe of a frame.
- R4: With REFLECT_IN set, each group of 8 data bits enters the engine with the last-received bit of the group first. The payload output keeps arrival order.
- R5: After the data bits, the remainder is bit-reversed when REFLECT_OUT is set, then xored with XOR_OUT. The expected checksum is sent with its bit CRC_W-1 first.
- R6: One cycle after the last checksum bit of a subframe is accepted, `res_valid` pulses for exactly one cycle. `res_idx` then carries the subframe number, 0 to NUM_SUB-1. `res_err` is 1 when any received checksum bit differs from the expected one, and 0 otherwise.
- R7: Cycles with `in_valid` low are ignored: they neither advance the position nor produce output.
- R8: Bits are accepted only inside a frame. A bit with `in_sof` high always starts a new frame at subframe 0, bit 0, including in the middle of a frame. Valid bits outside a frame produce nothing.
- R9: An accepted bit with `in_eof` high ends the frame. If it is not the last bit of the last subframe, the unfinished subframe gives no verdict, and later bits are ignored until the next `in_sof`.
- R10: Synchronous active-high `rst` clears `pay_valid` and `res_valid` and leaves the block outside any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_bit, in_sof and in_eof |
| in_bit | input | 1 | Received codeword bit |
| in_sof | input | 1 | First bit of a frame |
| in_eof | input | 1 | Final bit of a frame |
| pay_valid | output | 1 | pay_bit carries a data bit |
| pay_bit | output | 1 | Data bit with checksums removed |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_err | output | 1 | 1 when the subframe checksum mismatched |
| res_idx | output | max(1,clog2(NUM_SUB)) | Subframe number of the verdict |

## Verification
A position counter off by one moves the data/checksum boundary. That shows up in the very subframe concerned, as an extra or missing payload bit and a false verdict at its strobe. A start value not reloaded between subframes is invisible when the start value is zero. It therefore takes a non-zero start value, under which every subframe after the first reports a false error at its own strobe. A wrong reversal order or output mask flips the verdict of every clean subframe in the configuration that uses it. That error appears one cycle after the subframe's last checksum bit.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

    typedef enum logic {
        FR_IDLE   = 1'b0,
        FR_ACTIVE = 1'b1
    } frame_state_e;

    // Per-bit decode of the current input bit, produced by the sequencer
    typedef struct packed {
        logic take;       // bit accepted this cycle
        logic first;      // first bit of a subframe
        logic pay;        // data bit
        logic last_pay;   // final data bit of a subframe
        logic byte_end;   // closes a group of 8 bits
        logic chk;        // checksum bit
        logic chk_first;  // first checksum bit
        logic last_chk;   // final checksum bit of a subframe
    } bit_ctl_t;

endpackage

// File: rtl/crc_frame_seq.sv
module crc_frame_seq
    import crc_chk_pkg::*;
#(
    parameter int SUB_LEN = 48,
    parameter int CRC_W   = 16,
    parameter int NUM_SUB = 2,
    parameter int IDX_W   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    output bit_ctl_t         ctl,
    output logic [IDX_W-1:0] sub_idx
);

    localparam int PAY_LEN = SUB_LEN - CRC_W;
    localparam int POS_W   = $clog2(SUB_LEN);
    localparam logic [POS_W-1:0] POS_LAST     = POS_W'(SUB_LEN - 1);
    localparam logic [POS_W-1:0] POS_PAY_LAST = POS_W'(PAY_LEN - 1);
    localparam logic [POS_W-1:0] POS_CHK0     = POS_W'(PAY_LEN);
    localparam logic [IDX_W-1:0] SUB_LAST     = IDX_W'(NUM_SUB - 1);

    frame_state_e     state;
    logic [POS_W-1:0] pos, cur_pos;
    logic [IDX_W-1:0] sub, cur_sub;
    logic             frame_done;

    always_comb begin
        cur_pos        = in_sof ? '0 : pos;
        cur_sub        = in_sof ? '0 : sub;
        ctl            = '0;
        ctl.take       = in_valid && (in_sof || state == FR_ACTIVE);
        ctl.first      = ctl.take && (cur_pos == '0);
        ctl.pay        = ctl.take && (cur_pos <= POS_PAY_LAST);
        ctl.last_pay   = ctl.take && (cur_pos == POS_PAY_LAST);
        ctl.byte_end   = ctl.take && ((32'(cur_pos) % 32'd8) == 32'd7);
        ctl.chk        = ctl.take && (cur_pos > POS_PAY_LAST);
        ctl.chk_first  = ctl.take && (cur_pos == POS_CHK0);
        ctl.last_chk   = ctl.take && (cur_pos == POS_LAST);
        frame_done     = ctl.last_chk && (cur_sub == SUB_LAST);
        sub_idx        = cur_sub;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FR_IDLE;
            pos   <= '0;
            sub   <= '0;
        end else if (ctl.take) begin
            state <= (in_eof || frame_done) ? FR_IDLE : FR_ACTIVE;
            if (ctl.last_chk) begin
                pos <= '0;
                sub <= (cur_sub == SUB_LAST) ? '0 : cur_sub + 1'b1;
            end else begin
                pos <= cur_pos + 1'b1;
                sub <= cur_sub;
            end
        end
    end

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_LAST);                                             // R1
    AST_SUB_BOUND: assert property (@(posedge clk) disable iff (rst)
        sub <= SUB_LAST);                                             // R6
    AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (ctl.take && in_eof) |=> (state == FR_IDLE));                 // R9

endmodule

// File: rtl/crc_rem_unit.sv
module crc_rem_unit
    import crc_chk_pkg::*;
#(
    parameter int                CRC_W       = 16,
    parameter logic [CRC_W-1:0]  POLY        = 16'h1021,
    parameter logic [CRC_W-1:0]  INIT        = '0,
    parameter logic [CRC_W-1:0]  XOR_OUT     = '0,
    parameter bit                REFLECT_IN  = 1'b0,
    parameter bit                REFLECT_OUT = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_ctl_t ctl,
    input  logic     in_bit,
    output logic     err_now
);

    logic [CRC_W-1:0] rem, base, crc_nx, fin;
    logic             sticky, mism;
    wire              unused_ctl = ctl.last_chk;

    function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic b);
        return {c[CRC_W-2:0], 1'b0} ^ (((c[CRC_W-1] ^ b) == 1'b1) ? POLY : '0);
    endfunction

    function automatic logic [CRC_W-1:0] flip(input logic [CRC_W-1:0] c);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = c[CRC_W-1-i];
        return r;
    endfunction

    assign base = ctl.first ? INIT : rem;

    generate
        if (REFLECT_IN) begin : g_byte_in
            logic [6:0] byte_q;
            logic [7:0] byte_nx;
            assign byte_nx = {byte_q, in_bit};
            always_comb begin
                crc_nx = base;
                if (ctl.byte_end) begin
                    // byte_nx[0] is the last bit received: it enters first
                    for (int i = 0; i < 8; i++) crc_nx = step(crc_nx, byte_nx[i]);
                end
            end
            always_ff @(posedge clk) begin
                if (rst)                      byte_q <= '0;
                else if (ctl.take && ctl.pay) byte_q <= byte_nx[6:0];
            end
        end else begin : g_bit_in
            wire unused_byte = ctl.byte_end;
            assign crc_nx = step(base, in_bit);
        end
    endgenerate

    assign fin     = (REFLECT_OUT ? flip(crc_nx) : crc_nx) ^ XOR_OUT;
    assign mism    = ctl.chk && (in_bit != rem[CRC_W-1]);
    assign err_now = ctl.chk_first ? mism : (sticky | mism);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem    <= '0;
            sticky <= 1'b0;
        end else begin
            if (ctl.pay)      rem <= ctl.last_pay ? fin : crc_nx;
            else if (ctl.chk) rem <= {rem[CRC_W-2:0], 1'b0};
            if (ctl.chk)      sticky <= err_now;
        end
    end

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ctl.chk && !ctl.chk_first && !ctl.first && sticky) |=> sticky);   // R6

endmodule

// File: rtl/crc_subframe_checker.sv
module crc_subframe_checker
    import crc_chk_pkg::*;
#(
    parameter int                CRC_W       = 16,
    parameter logic [CRC_W-1:0]  POLY        = 16'h1021,
    parameter logic [CRC_W-1:0]  INIT        = '0,
    parameter logic [CRC_W-1:0]  XOR_OUT     = '0,
    parameter bit                REFLECT_IN  = 1'b0,
    parameter bit                REFLECT_OUT = 1'b0,
    parameter int                NUM_SUB     = 2,
    parameter int                SUB_LEN     = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic in_sof,
    input  logic in_eof,
    output logic pay_valid,
    output logic pay_bit,
    output logic res_valid,
    output logic res_err,
    output logic [((NUM_SUB > 1) ? $clog2(NUM_SUB) : 1)-1:0] res_idx
);

    localparam int IDX_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;

    bit_ctl_t         ctl;
    logic [IDX_W-1:0] sub_idx;
    logic             err_now;

    crc_frame_seq #(
        .SUB_LEN (SUB_LEN),
        .CRC_W   (CRC_W),
        .NUM_SUB (NUM_SUB),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .ctl      (ctl),
        .sub_idx  (sub_idx)
    );

    crc_rem_unit #(
        .CRC_W       (CRC_W),
        .POLY        (POLY),
        .INIT        (INIT),
        .XOR_OUT     (XOR_OUT),
        .REFLECT_IN  (REFLECT_IN),
        .REFLECT_OUT (REFLECT_OUT)
    ) u_rem (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .in_bit  (in_bit),
        .err_now (err_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_valid <= 1'b0;
            pay_bit   <= 1'b0;
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_idx   <= '0;
        end else begin
            pay_valid <= ctl.pay;
            pay_bit   <= ctl.pay ? in_bit : 1'b0;
            res_valid <= ctl.last_chk;
            res_err   <= ctl.last_chk && err_now;
            if (ctl.last_chk) res_idx <= sub_idx;
        end
    end

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);                                    // R6
    AST_RES_NO_PAY: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !pay_valid);                                    // R1
    AST_PAY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> $past(in_valid));                               // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_idx <= IDX_W'(NUM_SUB - 1)));              // R6

endmodule

// File: tb/crc_subframe_checker_test.sv
`timescale 1ns/1ps
module crc_subframe_checker_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic in_v [0:2] = '{1'b0, 1'b0, 1'b0};
    logic in_b [0:2] = '{1'b0, 1'b0, 1'b0};
    logic in_s [0:2] = '{1'b0, 1'b0, 1'b0};
    logic in_e [0:2] = '{1'b0, 1'b0, 1'b0};
    logic pv [0:2];
    logic pb [0:2];
    logic rv [0:2];
    logic re [0:2];
    logic [0:0] ri0, ri2;
    logic [1:0] ri1;

    crc_subframe_checker uut (
        .clk(clk), .rst(rst), .in_valid(in_v[0]), .in_bit(in_b[0]),
        .in_sof(in_s[0]), .in_eof(in_e[0]), .pay_valid(pv[0]), .pay_bit(pb[0]),
        .res_valid(rv[0]), .res_err(re[0]), .res_idx(ri0));

    crc_subframe_checker #(.CRC_W(8), .POLY(8'h07), .INIT(8'hFF), .XOR_OUT(8'h55),
        .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1), .NUM_SUB(3), .SUB_LEN(24)) uut_refl (
        .clk(clk), .rst(rst), .in_valid(in_v[1]), .in_bit(in_b[1]),
        .in_sof(in_s[1]), .in_eof(in_e[1]), .pay_valid(pv[1]), .pay_bit(pb[1]),
        .res_valid(rv[1]), .res_err(re[1]), .res_idx(ri1));

    crc_subframe_checker #(.CRC_W(3), .POLY(3'b101), .INIT(3'b000), .XOR_OUT(3'b000),
        .NUM_SUB(2), .SUB_LEN(8)) uut_small (
        .clk(clk), .rst(rst), .in_valid(in_v[2]), .in_bit(in_b[2]),
        .in_sof(in_s[2]), .in_eof(in_e[2]), .pay_valid(pv[2]), .pay_bit(pb[2]),
        .res_valid(rv[2]), .res_err(re[2]), .res_idx(ri2));

    int checks = 0;
    int errors = 0;

    // Monitor: outputs are registered, sampled at the falling edge
    logic pout [0:2][0:255];
    int   pn   [0:2] = '{0, 0, 0};
    logic rerr [0:2][0:7];
    int   ridx [0:2][0:7];
    int   rn   [0:2] = '{0, 0, 0};

    always @(negedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (pv[k] === 1'b1) begin
                if (pn[k] < 256) pout[k][pn[k]] = pb[k];
                pn[k]++;
            end
            if (rv[k] === 1'b1) begin
                if (rn[k] < 8) begin
                    rerr[k][rn[k]] = re[k];
                    ridx[k][rn[k]] = (k == 0) ? int'(ri0) : (k == 1) ? int'(ri1) : int'(ri2);
                end
                rn[k]++;
            end
        end
    end

    // Instance configurations, mirrored from the instantiations above
    function automatic int cw(int k);   return (k == 0) ? 16 : (k == 1) ? 8 : 3;  endfunction
    function automatic int csub(int k); return (k == 1) ? 3 : 2;                  endfunction
    function automatic int clen(int k); return (k == 0) ? 48 : (k == 1) ? 24 : 8; endfunction
    function automatic logic [15:0] cpoly(int k);
        return (k == 0) ? 16'h1021 : (k == 1) ? 16'h0007 : 16'h0005;
    endfunction
    function automatic logic [15:0] cinit(int k); return (k == 1) ? 16'h00FF : 16'h0000; endfunction
    function automatic logic [15:0] cxor(int k);  return (k == 1) ? 16'h0055 : 16'h0000; endfunction
    function automatic bit crefl(int k);          return (k == 1);                      endfunction

    logic pbits [0:255];
    logic fbits [0:255];

    // Requirement model of R2..R5 for one subframe starting at frame index start
    function automatic logic [15:0] model_crc(int k, int start);
        int w = cw(k);
        int pl = clen(k) - w;
        logic [15:0] mask = 16'((32'd1 << w) - 1);
        logic [15:0] crc = cinit(k);
        logic [15:0] r = '0;
        for (int i = 0; i < pl; i++) begin
            int idx = crefl(k) ? start + (i / 8) * 8 + 7 - (i % 8) : start + i;
            logic fb = crc[w-1] ^ fbits[idx];
            crc = (crc << 1) & mask;
            if (fb) crc = crc ^ cpoly(k);
        end
        if (crefl(k)) begin
            for (int j = 0; j < w; j++) r[j] = crc[w-1-j];
            crc = r;
        end
        return (crc ^ cxor(k)) & mask;
    endfunction

    task automatic build(int k, int flipat);
        int w = cw(k);
        int len = clen(k);
        int pl = len - w;
        for (int s = 0; s < csub(k); s++) begin
            logic [15:0] c;
            for (int j = 0; j < pl; j++) fbits[s*len + j] = pbits[s*pl + j];
            c = model_crc(k, s*len);
            for (int j = 0; j < w; j++) fbits[s*len + pl + j] = c[w-1-j];
        end
        if (flipat >= 0) fbits[flipat] = ~fbits[flipat];
    endtask

    task automatic clr_mon();
        for (int k = 0; k < 3; k++) begin pn[k] = 0; rn[k] = 0; end
    endtask

    task automatic drive_bit(int k, logic b, logic s, logic e);
        @(negedge clk);
        in_v[k] = 1'b1; in_b[k] = b; in_s[k] = s; in_e[k] = e;
    endtask

    task automatic idle(int k);
        @(negedge clk);
        in_v[k] = 1'b0; in_s[k] = 1'b0; in_e[k] = 1'b0;
    endtask

    task automatic send(int k, int first, int count, bit sof, bit eof, bit gap);
        for (int i = 0; i < count; i++) begin
            if (gap && (i % 5 == 3)) idle(k);
            drive_bit(k, fbits[first + i], sof && (i == 0), eof && (i == count - 1));
        end
        idle(k);
        repeat (3) @(negedge clk);
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Verdicts and payload of one complete frame
    task automatic verify(int k, int flipat, string req);
        int len = clen(k);
        int pl = len - cw(k);
        int bad = 0;
        check(req, "verdict count", rn[k], csub(k));
        for (int s = 0; s < csub(k); s++) begin
            check(req, "res_err", int'(rerr[k][s]), (flipat >= 0 && flipat / len == s) ? 1 : 0);
            check(req, "res_idx", ridx[k][s], s);
        end
        check("R1", "payload count", pn[k], csub(k) * pl);
        for (int s = 0; s < csub(k); s++)
            for (int j = 0; j < pl; j++)
                if (pout[k][s*pl + j] !== fbits[s*len + j]) bad++;
        check("R1", "payload mismatches", bad, 0);
    endtask

    // Table: {gap, flip position (255 = none), 64 payload bits}
    localparam logic [72:0] VEC [0:5] = '{
        {1'b0, 8'd255, 64'h0123_4567_89AB_CDEF},
        {1'b0, 8'd5,   64'hFFFF_FFFF_0000_0000},
        {1'b0, 8'd90,  64'hDEAD_BEEF_CAFE_F00D},
        {1'b1, 8'd255, 64'h0000_0000_0000_0000},
        {1'b1, 8'd40,  64'h8000_0001_1234_5678},
        {1'b0, 8'd47,  64'hA5A5_5A5A_3C3C_C3C3}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10", "pay_valid after reset", int'(pv[0]), 0);
        check("R10", "res_valid after reset", int'(rv[0]), 0);
        check("R10", "res_valid small after reset", int'(rv[2]), 0);

        // Table walk on the 16-bit configuration (R2, R6, R7 gaps)
        for (int i = 0; i < 6; i++) begin
            logic [63:0] pl = VEC[i][63:0];
            int fl = (VEC[i][71:64] == 8'd255) ? -1 : int'(VEC[i][71:64]);
            for (int j = 0; j < 64; j++) pbits[j] = pl[63 - j];
            build(0, fl);
            clr_mon();
            send(0, 0, 96, 1'b1, 1'b1, VEC[i][72]);
            verify(0, fl, VEC[i][72] ? "R7" : "R2");
        end

        // Reflected configuration with non-zero start value and output mask
        for (int j = 0; j < 48; j++) pbits[j] = 1'((48'hC0FFEE_123456 >> (47 - j)) & 48'd1);
        build(1, -1);
        clr_mon();
        send(1, 0, 72, 1'b1, 1'b1, 1'b0);
        verify(1, -1, "R3_R4_R5");
        build(1, 71);
        clr_mon();
        send(1, 0, 72, 1'b1, 1'b1, 1'b1);
        verify(1, 71, "R5");

        // Small example: two 8-bit subframes, third bit corrupted
        begin
            logic [9:0] sp = 10'b1011001110;
            for (int j = 0; j < 10; j++) pbits[j] = sp[9 - j];
        end
        build(2, 2);
        clr_mon();
        send(2, 0, 16, 1'b1, 1'b1, 1'b0);
        verify(2, 2, "R6");

        // R8: valid bits without a start marker are ignored
        build(2, -1);
        clr_mon();
        send(2, 0, 16, 1'b0, 1'b1, 1'b0);
        check("R8", "payload without sof", pn[2], 0);
        check("R8", "verdicts without sof", rn[2], 0);

        // R8: start marker in mid-frame restarts
        clr_mon();
        for (int i = 0; i < 3; i++) drive_bit(2, fbits[i], i == 0, 1'b0);
        send(2, 0, 16, 1'b1, 1'b1, 1'b0);
        check("R8", "restart verdict count", rn[2], 2);
        check("R8", "restart err0", int'(rerr[2][0]), 0);
        check("R8", "restart err1", int'(rerr[2][1]), 0);
        check("R8", "restart payload count", pn[2], 13);

        // R9: early end marker drops the partial subframe
        clr_mon();
        send(2, 0, 4, 1'b1, 1'b1, 1'b0);
        send(2, 4, 12, 1'b0, 1'b0, 1'b0);
        check("R9", "early eof payload count", pn[2], 4);
        check("R9", "early eof verdicts", rn[2], 0);
        clr_mon();
        send(2, 0, 16, 1'b1, 1'b1, 1'b0);
        verify(2, -1, "R9");

        // R10: reset mid-frame leaves the block outside any frame
        for (int i = 0; i < 3; i++) drive_bit(2, fbits[i], i == 0, 1'b0);
        @(negedge clk);
        in_v[2] = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clr_mon();
        send(2, 3, 13, 1'b0, 1'b1, 1'b0);
        check("R10", "payload after mid reset", pn[2], 0);
        check("R10", "verdicts after mid reset", rn[2], 0);

        summary();
        $finish;
    end

endmodule